// File: doc/BRIEF.md
# Barcode bar-width recorder

This block turns a one-bit scanner video signal into a list of bar widths in shared memory. A processor starts it by putting a trigger address on its address lines. The block then becomes bus master. It watches the video line for level changes while the scan-active input is high. Each time the level changes, it writes the length of the bar that just ended, counted in clock cycles, as one byte. The writes go to consecutive offsets of a fixed 256-byte page. Dark and light bars alternate in the list, in the order they were scanned.

A pass ends in one of two ways: the programmed number of bars has been stored, or the scan ends. The block then drops its bus-drive enable and raises an interrupt. The interrupt stays up until the processor issues the trigger address again or the block is reset. Converting the widths into a price is left to software.

Top module: `bar_width_recorder`

## Requirements
- R1: After a synchronous reset, `bus_oe`, `mem_we` and `irq` are low.
- R2: While idle, a cycle with `cpu_addr_valid` high and `cpu_addr` equal to `TRIG_ADDR` (default 12'hFF0) starts a pass. From the next cycle `bus_oe` is high and `irq` is low.
- R3: Measurement begins at the first video change seen while `scan_active` is high. Video changes before that point are ignored. Each stored width is the number of clock cycles between two consecutive video changes.
- R4: Widths are written one per `mem_we` pulse. The address is 12 bits: the upper 4 bits are the page and the lower 8 bits are the offset. The page is always 13 (addresses 12'hD00 upward). The offset starts at 0 for each pass and goes up by one per write.
- R5: A bar of 255 cycles or more is recorded as 255.
- R6: A pass stops after `bar_limit` widths have been written. A `bar_limit` of 0 ends the pass with no write.
- R7: If `scan_active` goes low during measurement, the pass ends. The bar still in progress is not written.
- R8: The cycle after the final write, or after the scan end is seen, `bus_oe` is low and `irq` is high.
- R9: `irq` stays high until a new trigger or a reset. A new trigger clears `irq` and the next pass writes from offset 0 again.
- R10: Any address other than the trigger address is ignored. A trigger issued during a pass is also ignored. The pass continues with consecutive offsets and stops at its limit.
- R11: `mem_we` is high only while `bus_oe` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 12 | Processor address bus |
| cpu_addr_valid | input | 1 | Processor address strobe |
| video | input | 1 | Scanner video level |
| scan_active | input | 1 | High while a scan is in progress |
| bar_limit | input | 8 | Maximum bars to store per pass |
| mem_addr | output | 12 | Memory write address (page and offset) |
| mem_wdata | output | 8 | Bar width byte |
| mem_we | output | 1 | Memory write strobe, one cycle per width |
| bus_oe | output | 1 | Drive enable for address and data buses |
| irq | output | 1 | Completion interrupt |

## Verification
The bench builds the block with its default parameters. These are an 8-bit width counter, an 8-bit limit, page 13 and trigger address 12'hFF0. With an 8-bit counter, a 300-cycle bar is long enough to reach the saturation value of 255. The 8-bit limit also lets the bench use a limit of zero, and a limit larger than the number of bars scanned so that the scan-end path is what stops the pass. Directed passes cover re-triggering, a trigger during a pass, and video changes that arrive before the scan starts.

// File: rtl/bwr_pkg.sv
package bwr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARM,
    ST_MEAS,
    ST_FIN
  } bwr_state_e;
endpackage

// File: rtl/bwr_edge_det.sv
module bwr_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic sig,
  output logic toggle
);
  logic sig_q;

  always_ff @(posedge clk) begin
    if (rst) sig_q <= 1'b0;
    else     sig_q <= sig;
  end

  assign toggle = sig ^ sig_q;
endmodule

// File: rtl/bwr_run_counter.sv
module bwr_run_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)                count <= '0;
    else if (restart)       count <= CNT_W'(1);
    else if (count != MAXV) count <= count + CNT_W'(1);
  end
endmodule

// File: rtl/bar_width_recorder.sv
module bar_width_recorder #(
  parameter int                ADDR_W    = 12,
  parameter int                PAGE_W    = 4,
  parameter int                DATA_W    = 8,
  parameter int                LIMIT_W   = 8,
  parameter int                PAGE_IDX  = 13,
  parameter logic [ADDR_W-1:0] TRIG_ADDR = 12'hFF0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic               cpu_addr_valid,
  input  logic               video,
  input  logic               scan_active,
  input  logic [LIMIT_W-1:0] bar_limit,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  output logic               mem_we,
  output logic               bus_oe,
  output logic               irq
);
  import bwr_pkg::*;

  localparam int                OFF_W    = ADDR_W - PAGE_W;
  localparam logic [PAGE_W-1:0] PAGE_SEL = PAGE_W'(PAGE_IDX);

  bwr_state_e         state;
  logic [OFF_W-1:0]   offset;
  logic [LIMIT_W-1:0] bar_cnt;
  logic               toggle;
  logic [DATA_W-1:0]  run_len;
  logic               trig_hit;
  logic               last_bar;

  bwr_edge_det edge_i (
    .clk    (clk),
    .rst    (rst),
    .sig    (video),
    .toggle (toggle)
  );

  bwr_run_counter #(.CNT_W(DATA_W)) cnt_i (
    .clk     (clk),
    .rst     (rst),
    .restart (toggle),
    .count   (run_len)
  );

  assign trig_hit = cpu_addr_valid && (cpu_addr == TRIG_ADDR);
  assign last_bar = ({1'b0, bar_cnt} + (LIMIT_W+1)'(1)) == {1'b0, bar_limit};

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bus_oe    <= 1'b0;
      irq       <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      offset    <= '0;
      bar_cnt   <= '0;
    end else begin
      mem_we <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (trig_hit) begin
            state   <= ST_ARM;
            bus_oe  <= 1'b1;
            irq     <= 1'b0;
            offset  <= '0;
            bar_cnt <= '0;
          end
        end
        ST_ARM: begin
          if (bar_limit == '0)           state <= ST_FIN;
          else if (scan_active && toggle) state <= ST_MEAS;
        end
        ST_MEAS: begin
          if (!scan_active) begin
            state <= ST_FIN;
          end else if (toggle) begin
            mem_we    <= 1'b1;
            mem_addr  <= {PAGE_SEL, offset};
            mem_wdata <= run_len;
            offset    <= offset + OFF_W'(1);
            bar_cnt   <= bar_cnt + LIMIT_W'(1);
            if (last_bar) state <= ST_FIN;
          end
        end
        ST_FIN: begin
          bus_oe <= 1'b0;
          irq    <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bar_width_recorder_chk.sv
module bar_width_recorder_chk #(
  parameter int                ADDR_W    = 12,
  parameter int                PAGE_W    = 4,
  parameter int                DATA_W    = 8,
  parameter int                LIMIT_W   = 8,
  parameter int                PAGE_IDX  = 13,
  parameter logic [ADDR_W-1:0] TRIG_ADDR = 12'hFF0
) (
  input logic               clk,
  input logic               rst,
  input logic [ADDR_W-1:0]  cpu_addr,
  input logic               cpu_addr_valid,
  input logic [ADDR_W-1:0]  mem_addr,
  input logic [DATA_W-1:0]  mem_wdata,
  input logic               mem_we,
  input logic               bus_oe,
  input logic               irq
);
  localparam int                OFF_W    = ADDR_W - PAGE_W;
  localparam logic [PAGE_W-1:0] PAGE_SEL = PAGE_W'(PAGE_IDX);

  logic [OFF_W-1:0] exp_off;

  always_ff @(posedge clk) begin
    if (rst || !bus_oe) exp_off <= '0;
    else if (mem_we)    exp_off <= exp_off + OFF_W'(1);
  end

  a_r11_we_with_oe: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> bus_oe);

  a_r4_page_fixed: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_addr[ADDR_W-1:OFF_W] == PAGE_SEL);

  a_r4_offsets_consecutive: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_addr[OFF_W-1:0] == exp_off);

  a_r8_irq_bus_released: assert property (@(posedge clk) disable iff (rst)
    irq |-> !bus_oe);

  a_r9_irq_held: assert property (@(posedge clk) disable iff (rst)
    (irq && !(cpu_addr_valid && cpu_addr == TRIG_ADDR)) |=> irq);

  a_r3_width_nonzero: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_wdata != '0);
endmodule

bind bar_width_recorder bar_width_recorder_chk #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W),
  .LIMIT_W(LIMIT_W), .PAGE_IDX(PAGE_IDX), .TRIG_ADDR(TRIG_ADDR)
) chk_i (
  .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_addr_valid(cpu_addr_valid),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
  .bus_oe(bus_oe), .irq(irq)
);

// File: tb/bar_width_recorder_tb_top.sv
module bar_width_recorder_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] cpu_addr = '0;
  logic        cpu_addr_valid = 1'b0;
  logic        video = 1'b0;
  logic        scan_active = 1'b0;
  logic [7:0]  bar_limit = '0;
  logic [11:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_we;
  logic        bus_oe;
  logic        irq;

  int total = 0;
  int bad   = 0;
  int nw    = 0;
  logic [7:0]  wd [64];
  logic [11:0] wa [64];

  always #4 clk = ~clk;

  bar_width_recorder dut_i (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_addr_valid(cpu_addr_valid),
    .video(video), .scan_active(scan_active), .bar_limit(bar_limit),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .bus_oe(bus_oe), .irq(irq)
  );

  always @(posedge clk) begin
    if (!rst && mem_we && nw < 64) begin
      wa[nw] = mem_addr;
      wd[nw] = mem_wdata;
      nw = nw + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic fire(input logic [11:0] a);
    cpu_addr = a;
    cpu_addr_valid = 1'b1;
    @(negedge clk);
    cpu_addr_valid = 1'b0;
  endtask

  task automatic bar(input logic lv, input int n);
    video = lv;
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_writes(input string req, input int exp_n,
                            input int w0, input int w1, input int w2, input int w3);
    int ev[4];
    ev = '{w0, w1, w2, w3};
    chk(nw == exp_n, req, "write count", nw, exp_n);
    for (int i = 0; i < exp_n && i < nw && i < 4; i++) begin
      chk(wd[i] == ev[i], req, "width", wd[i], ev[i]);
      chk(wa[i] == 12'hD00 + i, "R4", "address", wa[i], 12'hD00 + i);
    end
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!bus_oe && !mem_we && !irq, "R1", "outputs after reset",
        {bus_oe, mem_we, irq}, 0);
  endtask

  task automatic t_basic;
    nw = 0;
    bar_limit = 8'd4;
    scan_active = 1'b1;
    video = 1'b0;
    fire(12'hFF0);
    chk(bus_oe && !irq, "R2", "bus taken after trigger", {bus_oe, irq}, 2);
    repeat (5) @(negedge clk);
    bar(1'b1, 5);
    bar(1'b0, 3);
    bar(1'b1, 7);
    bar(1'b0, 2);
    video = 1'b1;
    @(negedge clk);
    chk(mem_we && bus_oe, "R8", "final write with bus held", {mem_we, bus_oe}, 3);
    @(negedge clk);
    chk(irq && !bus_oe && !mem_we, "R8", "released and interrupt",
        {irq, bus_oe, mem_we}, 4);
    chk_writes("R3", 4, 5, 3, 7, 2);
    chk(nw == 4, "R6", "limit honoured", nw, 4);
    fire(12'h123);
    repeat (10) @(negedge clk);
    chk(irq && !bus_oe, "R10", "other address ignored", {irq, bus_oe}, 2);
    chk(irq, "R9", "interrupt held", irq, 1);
  endtask

  task automatic t_saturate;
    nw = 0;
    bar_limit = 8'd2;
    fire(12'hFF0);
    chk(!irq && bus_oe, "R9", "retrigger clears interrupt", {irq, bus_oe}, 1);
    video = 1'b0;
    repeat (100) @(negedge clk);
    fire(12'hFF0);
    repeat (199) @(negedge clk);
    bar(1'b1, 4);
    bar(1'b0, 3);
    chk_writes("R5", 2, 255, 4, 0, 0);
    chk(irq && !bus_oe, "R10", "trigger in pass ignored", {irq, bus_oe}, 2);
  endtask

  task automatic t_scan_end;
    nw = 0;
    bar_limit = 8'd10;
    scan_active = 1'b0;
    fire(12'hFF0);
    bar(1'b1, 3);
    bar(1'b0, 3);
    bar(1'b1, 3);
    chk(nw == 0 && bus_oe && !irq, "R3", "changes before scan ignored",
        nw, 0);
    scan_active = 1'b1;
    repeat (2) @(negedge clk);
    bar(1'b0, 3);
    bar(1'b1, 6);
    bar(1'b0, 2);
    scan_active = 1'b0;
    repeat (3) @(negedge clk);
    chk_writes("R7", 2, 3, 6, 0, 0);
    chk(irq && !bus_oe, "R7", "scan end finishes pass", {irq, bus_oe}, 2);
  endtask

  task automatic t_limit_zero;
    nw = 0;
    bar_limit = 8'd0;
    scan_active = 1'b1;
    fire(12'hFF0);
    bar(1'b1, 3);
    bar(1'b0, 3);
    chk(nw == 0, "R6", "zero limit writes nothing", nw, 0);
    chk(irq && !bus_oe, "R6", "zero limit completes", {irq, bus_oe}, 2);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!irq, "R9", "reset clears interrupt", irq, 0);
  endtask

  initial begin
    t_reset;
    t_basic;
    t_saturate;
    t_scan_end;
    t_limit_zero;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog run did not finish actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule